// File: doc/BRIEF.md
# Password Unlock Unit

This block stores a 64-bit password as four 16-bit words and lets a sequencer program those words one at a time. Each stored word can be read back through an indexed read port. The stored words behave like one-time-programmable cells: they leave reset fully erased (all ones), and a program operation can only turn bits from one to zero.

The block also carries out the unlock command. An outside sequencer decodes the command prefix and hands the block three things: a start strobe, which opens an unlock session; one word strobe per supplied password word, which carries that word's index and value; and an end strobe, which closes the session. When the session closes, the block compares the four supplied words with the four stored words. If a word was supplied for every index and all four words match, the block raises its lock-release output for one cycle. The persistent-protection logic uses that pulse to clear its lock.

The supplied words may arrive in any order. If the same index arrives twice, the later value replaces the earlier one. A separate exit strobe abandons a session at any time.

Top module: `pw_unlock_unit`

## Requirements
- R1: After reset, every stored word reads 16'hFFFF and `lockRelease` is 0.
- R2: A cycle with `progEn` high sets stored word `progIdx` to its old value ANDed with `progData`, so programming can only clear bits. The new value is visible from the cycle after that edge.
- R3: `rdData` always shows the stored word selected by `rdIdx`, with no added register delay.
- R4: `unlockStart` opens a session and clears all four per-index "seen" flags.
- R5: Inside a session, a cycle with `wordEn` high records `wordData` as the candidate for `wordIdx` and sets that index's flag. Indices may come in any order, and a repeated index overwrites the earlier candidate.
- R6: A cycle with `unlockEnd` high inside a session, with all four flags set and every candidate equal to its stored word, makes `lockRelease` high in the next cycle only.
- R7: If any candidate differs from its stored word, `unlockEnd` produces no `lockRelease` pulse.
- R8: If fewer than four distinct indices have been seen, `unlockEnd` produces no `lockRelease` pulse.
- R9: `wordEn` and `unlockEnd` are ignored outside a session. `unlockEnd` closes the session, so a second `unlockEnd` without a new `unlockStart` produces no pulse. A word or end strobe in the same cycle as `unlockStart` is ignored.
- R10: `cmdExit` closes the session and clears all flags. It has priority over every other strobe in that cycle, and an `unlockEnd` in the same cycle produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progEn | input | 1 | Program one stored word |
| progIdx | input | 2 | Index of the word to program |
| progData | input | 16 | Value ANDed into the selected word |
| rdIdx | input | 2 | Index of the stored word to read |
| rdData | output | 16 | Stored word selected by `rdIdx` |
| unlockStart | input | 1 | Opens an unlock session |
| wordEn | input | 1 | A supplied password word is present |
| wordIdx | input | 2 | Index of the supplied word |
| wordData | input | 16 | Value of the supplied word |
| unlockEnd | input | 1 | Closes the session and triggers the compare |
| cmdExit | input | 1 | Abandons the session |
| lockRelease | output | 1 | One-cycle pulse on a successful unlock |

## Verification
The bench uses the default parameters, four words of 16 bits. With these values it can reach every index, both for the flag set and for the read multiplexer. Two rounds of programming exercise the clear-only AND behaviour. The unlock tests cover out-of-order delivery, an overwritten index, one wrong word, a missing index, strobes outside a session, and `cmdExit` colliding with `unlockEnd`. The behavioural reference model is compared with both outputs on every clock.

// File: rtl/pw_unlock_pkg.sv
package pw_unlock_pkg;
  typedef struct packed {
    logic capWord;
    logic progWord;
  } pwStrobes_t;
endpackage

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_unlock_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pwStrobes_t           strobes,
  input  logic [IDX_W-1:0]     progIdx,
  input  logic [WORD_W-1:0]    progData,
  input  logic [IDX_W-1:0]     capIdx,
  input  logic [WORD_W-1:0]    capData,
  input  logic [IDX_W-1:0]     rdIdx,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_WORDS-1:0] eqVec
);
  logic [WORD_W-1:0] storedW [NUM_WORDS];
  logic [WORD_W-1:0] candW   [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        storedW[i] <= '1;
        candW[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (strobes.progWord && progIdx == IDX_W'(i))
          storedW[i] <= storedW[i] & progData;
        if (strobes.capWord && capIdx == IDX_W'(i))
          candW[i] <= capData;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS; g++) begin : gEq
      assign eqVec[g] = (storedW[g] == candW[g]);
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (rdIdx == IDX_W'(i)) rdData = storedW[i];
  end
endmodule

// File: rtl/pw_control.sv
module pw_control
  import pw_unlock_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 progEn,
  input  logic                 unlockStart,
  input  logic                 wordEn,
  input  logic [IDX_W-1:0]     wordIdx,
  input  logic                 unlockEnd,
  input  logic                 cmdExit,
  input  logic [NUM_WORDS-1:0] eqVec,
  output pwStrobes_t           strobes,
  output logic                 sessionActive,
  output logic [NUM_WORDS-1:0] seenFlags,
  output logic                 lockRelease
);
  logic quiet;
  logic fire;

  assign quiet = sessionActive && !cmdExit && !unlockStart;
  assign fire  = quiet && unlockEnd && (&seenFlags) && (&eqVec);

  always_comb begin
    strobes          = '0;
    strobes.progWord = progEn;
    strobes.capWord  = quiet && wordEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sessionActive <= 1'b0;
      seenFlags     <= '0;
      lockRelease   <= 1'b0;
    end else begin
      lockRelease <= fire;
      if (cmdExit) begin
        sessionActive <= 1'b0;
        seenFlags     <= '0;
      end else if (unlockStart) begin
        sessionActive <= 1'b1;
        seenFlags     <= '0;
      end else if (sessionActive) begin
        if (unlockEnd) sessionActive <= 1'b0;
        if (wordEn) seenFlags[wordIdx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pw_unlock_unit.sv
module pw_unlock_unit
  import pw_unlock_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progEn,
  input  logic [IDX_W-1:0]  progIdx,
  input  logic [WORD_W-1:0] progData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdData,
  input  logic              unlockStart,
  input  logic              wordEn,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [WORD_W-1:0] wordData,
  input  logic              unlockEnd,
  input  logic              cmdExit,
  output logic              lockRelease
);
  pwStrobes_t            strobes;
  logic [NUM_WORDS-1:0]  eqVec;
  logic [NUM_WORDS-1:0]  seenFlags;
  logic                  sessionActive;

  pw_control #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .progEn(progEn), .unlockStart(unlockStart),
    .wordEn(wordEn), .wordIdx(wordIdx), .unlockEnd(unlockEnd),
    .cmdExit(cmdExit), .eqVec(eqVec), .strobes(strobes),
    .sessionActive(sessionActive), .seenFlags(seenFlags),
    .lockRelease(lockRelease)
  );

  pw_datapath #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .progIdx(progIdx), .progData(progData),
    .capIdx(wordIdx), .capData(wordData),
    .rdIdx(rdIdx), .rdData(rdData), .eqVec(eqVec)
  );
endmodule

// File: rtl/pw_unlock_checker.sv
module pw_unlock_checker #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 progEn,
  input logic [IDX_W-1:0]     rdIdx,
  input logic [WORD_W-1:0]    rdData,
  input logic                 unlockStart,
  input logic                 unlockEnd,
  input logic                 cmdExit,
  input logic                 sessionActive,
  input logic [NUM_WORDS-1:0] seenFlags,
  input logic                 lockRelease
);
  // R6: a release follows an end strobe taken inside a session
  a_r6_release_after_end: assert property (@(posedge clk) disable iff (!rstN)
    lockRelease |-> ($past(unlockEnd) && $past(sessionActive)));

  // R6: the release is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    lockRelease |=> !lockRelease);

  // R8: a release needs every index flag set in the cycle of the end strobe
  a_r8_all_seen: assert property (@(posedge clk) disable iff (!rstN)
    lockRelease |-> ($past(seenFlags) == {NUM_WORDS{1'b1}}));

  // R10: exit wins over an end strobe in the same cycle
  a_r10_exit_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cmdExit |=> (!lockRelease && !sessionActive && seenFlags == '0));

  // R2: a stored word never gains a one bit
  a_r2_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    $stable(rdIdx) |-> ((rdData & ~$past(rdData)) == '0));

  // R3: without programming the read word holds still
  a_r3_read_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdIdx) && !$past(progEn)) |-> $stable(rdData));

  // R4: a start without exit opens a session with no flags set
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (unlockStart && !cmdExit) |=> (sessionActive && seenFlags == '0));
endmodule

bind pw_unlock_unit pw_unlock_checker #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .progEn(progEn), .rdIdx(rdIdx), .rdData(rdData),
  .unlockStart(unlockStart), .unlockEnd(unlockEnd), .cmdExit(cmdExit),
  .sessionActive(sessionActive), .seenFlags(seenFlags),
  .lockRelease(lockRelease)
);

// File: tb/pw_unlock_unit_tb.sv
module pw_unlock_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progEn = 1'b0;
  logic [1:0]  progIdx = '0;
  logic [15:0] progData = '0;
  logic [1:0]  rdIdx = '0;
  logic [15:0] rdData;
  logic        unlockStart = 1'b0;
  logic        wordEn = 1'b0;
  logic [1:0]  wordIdx = '0;
  logic [15:0] wordData = '0;
  logic        unlockEnd = 1'b0;
  logic        cmdExit = 1'b0;
  logic        lockRelease;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  string curReq = "R1";

  pw_unlock_unit u_dut (
    .clk(clk), .rstN(rstN), .progEn(progEn), .progIdx(progIdx),
    .progData(progData), .rdIdx(rdIdx), .rdData(rdData),
    .unlockStart(unlockStart), .wordEn(wordEn), .wordIdx(wordIdx),
    .wordData(wordData), .unlockEnd(unlockEnd), .cmdExit(cmdExit),
    .lockRelease(lockRelease)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mStored[4];
  int mCand[4];
  bit mSeen[4];
  bit mActive;
  bit mRel;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mStored[i]) begin mStored[i] = 16'hFFFF; mCand[i] = 0; mSeen[i] = 0; end
      mActive = 0; mRel = 0;
    end else begin
      bit ok;
      bit open;
      open = mActive && !cmdExit && !unlockStart;
      ok = open && unlockEnd;
      foreach (mStored[i]) if (!mSeen[i] || mCand[i] != mStored[i]) ok = 0;
      mRel = ok;
      if (progEn) mStored[progIdx] = mStored[progIdx] & int'(progData);
      if (cmdExit) begin
        mActive = 0; foreach (mSeen[i]) mSeen[i] = 0;
      end else if (unlockStart) begin
        mActive = 1; foreach (mSeen[i]) mSeen[i] = 0;
      end else if (mActive) begin
        if (wordEn) begin mSeen[wordIdx] = 1; mCand[wordIdx] = int'(wordData); end
        if (unlockEnd) mActive = 0;
      end
    end
    #2;
    checks++;
    if (lockRelease !== mRel) begin
      errors++;
      $display("FAIL %s lockRelease act=%0b exp=%0b", curReq, lockRelease, mRel);
    end
    checks++;
    if (rdData !== 16'(mStored[rdIdx])) begin
      errors++;
      $display("FAIL %s rdData act=%h exp=%h", curReq, rdData, 16'(mStored[rdIdx]));
    end
    if (lockRelease === 1'b1) pulses++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input logic [1:0] i, input logic [15:0] d);
    @(negedge clk); progEn = 1; progIdx = i; progData = d;
    @(negedge clk); progEn = 0;
  endtask

  task automatic word(input logic [1:0] i, input logic [15:0] d);
    @(negedge clk); wordEn = 1; wordIdx = i; wordData = d;
    @(negedge clk); wordEn = 0;
  endtask

  task automatic startS();
    @(negedge clk); unlockStart = 1; @(negedge clk); unlockStart = 0;
  endtask

  task automatic endS();
    @(negedge clk); unlockEnd = 1; @(negedge clk); unlockEnd = 0;
  endtask

  task automatic readChk(input string req, input logic [1:0] i, input logic [15:0] exp);
    @(negedge clk); rdIdx = i; #1; chk(req, rdData, exp);
  endtask

  localparam logic [15:0] PW0 = 16'h1200, PW1 = 16'hA5A5, PW2 = 16'h0F0F, PW3 = 16'h8001;

  initial begin
    int p0;
    idle(3); rstN = 1; idle(1);
    curReq = "R1";
    chk("R1", lockRelease, 0);
    for (int i = 0; i < 4; i++) readChk("R1/R3", 2'(i), 16'hFFFF);

    curReq = "R2";
    prog(2'd0, 16'h1234); readChk("R2", 2'd0, 16'h1234);
    prog(2'd0, 16'hFF00); readChk("R2", 2'd0, PW0);
    prog(2'd0, 16'hFFFF); readChk("R2 no set", 2'd0, PW0);
    prog(2'd1, PW1); prog(2'd2, PW2); prog(2'd3, PW3);
    curReq = "R3";
    readChk("R3", 2'd1, PW1); readChk("R3", 2'd2, PW2); readChk("R3", 2'd3, PW3);

    curReq = "R5";
    p0 = pulses;
    startS(); word(2'd3, PW3); word(2'd0, PW0); word(2'd2, PW2); word(2'd1, PW1);
    endS(); idle(2);
    chk("R6 out-of-order match", pulses - p0, 1);

    curReq = "R7";
    p0 = pulses;
    startS(); word(2'd0, PW0); word(2'd1, PW1 ^ 16'h0010); word(2'd2, PW2); word(2'd3, PW3);
    endS(); idle(2);
    chk("R7 mismatch", pulses - p0, 0);

    curReq = "R8";
    p0 = pulses;
    startS(); word(2'd0, PW0); word(2'd1, PW1); word(2'd1, PW1); word(2'd3, PW3);
    endS(); idle(2);
    chk("R8 incomplete", pulses - p0, 0);

    curReq = "R4";
    p0 = pulses;
    startS(); word(2'd2, PW2); startS(); word(2'd0, PW0); word(2'd1, PW1); word(2'd3, PW3);
    endS(); idle(2);
    chk("R4 restart clears flags", pulses - p0, 0);

    curReq = "R5";
    p0 = pulses;
    startS(); word(2'd1, 16'h0000); word(2'd0, PW0); word(2'd2, PW2); word(2'd3, PW3);
    word(2'd1, PW1); endS(); idle(2);
    chk("R5 overwrite index", pulses - p0, 1);

    curReq = "R9";
    p0 = pulses;
    endS(); idle(2);
    chk("R9 second end", pulses - p0, 0);
    word(2'd0, 16'h0); endS(); idle(2);
    chk("R9 outside session", pulses - p0, 0);
    startS(); word(2'd0, PW0); word(2'd1, PW1); word(2'd2, PW2);
    @(negedge clk); unlockStart = 1; wordEn = 1; wordIdx = 2'd3; wordData = PW3;
    @(negedge clk); unlockStart = 0; wordEn = 0;
    endS(); idle(2);
    chk("R9 word with start ignored", pulses - p0, 0);

    curReq = "R10";
    p0 = pulses;
    startS(); word(2'd0, PW0); word(2'd1, PW1); word(2'd2, PW2); word(2'd3, PW3);
    @(negedge clk); cmdExit = 1; unlockEnd = 1;
    @(negedge clk); cmdExit = 0; unlockEnd = 0;
    idle(2);
    chk("R10 exit beats end", pulses - p0, 0);
    startS(); word(2'd0, PW0); word(2'd1, PW1); word(2'd2, PW2); word(2'd3, PW3);
    @(negedge clk); cmdExit = 1; @(negedge clk); cmdExit = 0;
    endS(); idle(2);
    chk("R10 exit closes session", pulses - p0, 0);

    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule